// File: doc/BRIEF.md
# Slow-Clock Watchdog Timer

This block is a watchdog that runs directly on a 32768 Hz slow clock. A prescaler divides that clock by 128, so a 12-bit down-counter moves at 256 steps per second. A timeout of s seconds corresponds to a reload value of s*256-1, and a request for zero seconds corresponds to 0. The widest setting, 16 seconds, is a reload value of 0xFFF. When the counter is at zero and takes one more step, the block records an underflow and raises a fault interrupt, a reset request, or both, according to the enable bits. It then reloads and keeps counting.

Software talks to the block over a simple word-wide register port. There are three registers. The control register restarts the counter, but only when the write carries a key. The mode register holds the reload value, a restart window, the disable bit, the two fault enables and two halt enables. The status register holds the event flags and clears them when it is read. A write to the mode register also restarts the counter. After any restart, writes to the control and mode registers are refused for three slow-clock periods. A restart that arrives while the counter is still above the window value counts as a fault.

Top module: `wdt_slowclk`

## Requirements
- R1: After reset the mode register reads 0x01FFFFFF: disable set, window 0xFFF, reload 0xFFF, all enables clear. The status register reads 0 and both fault outputs are low.
- R2: The mode register fields are: reload [11:0], window [23:12], disable [24], interrupt enable [25], reset enable [26], idle-halt [27], debug-halt [28]. While enabled, the counter steps down once every 128 clocks. It underflows (reload+1)*128 clocks after a restart, at which point status bit 0 is set. The counter then reloads from the reload field and carries on counting.
- R3: A write to the control register at address 0 restarts the counter only if bits [31:24] equal 0xA5 and bit 0 is 1. A restart reloads the counter and clears the prescaler. A control write with any other key has no effect.
- R4: An accepted write to the mode register at address 1 restarts the counter from the new effective reload value.
- R5: For three clock periods after any restart, writes to the control register and to the mode register are ignored. The fourth clock after the restart accepts writes again.
- R6: A mode write whose disable bit is 1 leaves the reload and window fields unchanged, and the other fields still take the written values. A mode write whose disable bit is 0 updates every field.
- R7: On a fault, fault_irq_o is high while a status flag is set and the interrupt enable is 1. When the reset enable is 1, rst_req_o pulses high for one clock.
- R8: With idle-halt set, counting freezes on every clock where idle_i is high. With debug-halt set, counting freezes on every clock where dbg_i is high. An input whose halt bit is clear has no effect.
- R9: A keyed restart while enabled with the counter above the window value sets status bit 1 and counts as a fault. It still reloads the counter. A keyed restart at or below the window value raises no flag.
- R10: Reading the status register at address 2 returns {30'b0, window error, underflow} and clears both flags.
- R11: While the disable bit is set the counter does not move and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock, 32768 Hz nominal |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on address 2) |
| addr | input | 2 | Register address: 0 control, 1 mode, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| idle_i | input | 1 | Idle indication, halts counting when idle-halt is set |
| dbg_i | input | 1 | Debug-halt indication, halts counting when debug-halt is set |
| fault_irq_o | output | 1 | Fault interrupt, level |
| rst_req_o | output | 1 | Reset request, one-clock pulse |

## Verification
The assertions check these rules on every cycle:
- a keyed restart loads the reload field into the counter;
- a restart always opens the lockout, and a mode write inside the lockout changes nothing;
- a mode write that sets the disable bit keeps the reload and window fields;
- the underflow flag only rises from a zero count;
- the counter holds still while disabled or halted;
- a reset request never appears without its enable.

The directed scenarios cover the rest by measuring the clock on which the interrupt first appears:
- the 128-clock step rate;
- the key check;
- the exact edge where the lockout ends;
- the halt extension;
- the reload done by a valid windowed restart.

// File: rtl/wdt_slowclk_pkg.sv
`timescale 1ns/1ps
package wdt_slowclk_pkg;
  localparam int CNT_W         = 12;
  localparam int TICKS_PER_SEC = 256;
  localparam logic [7:0] CTRL_KEY = 8'hA5;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef struct packed {
    logic             dbg_halt;   // [28]
    logic             idle_halt;  // [27]
    logic             rst_en;     // [26]
    logic             irq_en;     // [25]
    logic             dis;        // [24]
    logic [CNT_W-1:0] window;     // [23:12]
    logic [CNT_W-1:0] reload;     // [11:0]
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  function automatic logic [CNT_W-1:0] secs_to_ticks(input int unsigned s);
    if (s == 0) return '0;
    return CNT_W'(s * TICKS_PER_SEC - 1);
  endfunction

  function automatic logic win_ok(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] win);
    return cnt <= win;
  endfunction

  // New mode value; timing fields are frozen when the write leaves the block disabled.
  function automatic mode_t mode_merge(input mode_t old, input logic [31:0] wd);
    mode_t nx;
    nx = mode_t'(wd[MODE_W-1:0]);
    if (nx.dis) begin
      nx.reload = old.reload;
      nx.window = old.window;
    end
    return nx;
  endfunction
endpackage

// File: rtl/wdt_slowclk_regs.sv
`timescale 1ns/1ps
module wdt_slowclk_regs
  import wdt_slowclk_pkg::*;
#(
  parameter int LOCK_CYC = 3,
  parameter int DEF_SECS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output mode_t            mode_q,
  output logic             ctrl_rst_ev,
  output logic             mode_wr_ev,
  output logic             restart_ev,
  output logic [CNT_W-1:0] load_val,
  output logic             lock_active
);
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] DEF_LOAD = secs_to_ticks(DEF_SECS);

  logic [LW-1:0] lock_q;
  logic          wr_ok;
  mode_t         mode_nx;

  assign lock_active = (lock_q != '0);
  assign wr_ok       = wr_en & ~lock_active;
  assign ctrl_rst_ev = wr_ok & (addr == A_CTRL) & (wdata[31:24] == CTRL_KEY) & wdata[0];
  assign mode_wr_ev  = wr_ok & (addr == A_MODE);
  assign restart_ev  = ctrl_rst_ev | mode_wr_ev;
  assign mode_nx     = mode_merge(mode_q, wdata);
  assign load_val    = mode_wr_ev ? mode_nx.reload : mode_q.reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{dbg_halt: 1'b0, idle_halt: 1'b0, rst_en: 1'b0, irq_en: 1'b0,
                  dis: 1'b1, window: DEF_LOAD, reload: DEF_LOAD};
    end else if (mode_wr_ev) begin
      mode_q <= mode_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lock_q <= '0;
    else if (restart_ev)       lock_q <= LW'(LOCK_CYC);
    else if (lock_q != '0)     lock_q <= lock_q - LW'(1);
  end
endmodule

// File: rtl/wdt_slowclk_counter.sv
`timescale 1ns/1ps
module wdt_slowclk_counter
  import wdt_slowclk_pkg::*;
#(
  parameter int PRESC_DIV = 128,
  parameter int DEF_SECS  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic             unf_ev
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [CNT_W-1:0] DEF_LOAD = secs_to_ticks(DEF_SECS);

  logic tick;

  generate
    if (PRESC_DIV > 1) begin : g_presc
      localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);
      logic [PW-1:0] presc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     presc_q <= '0;
        else if (load)  presc_q <= '0;
        else if (run)   presc_q <= (presc_q == LAST) ? '0 : presc_q + PW'(1);
      end
      assign tick = run & (presc_q == LAST);
    end else begin : g_nopresc
      assign tick = run;
    end
  endgenerate

  assign unf_ev = tick & (cnt_q == '0) & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= DEF_LOAD;
    else if (load)  cnt_q <= load_val;
    else if (tick)  cnt_q <= (cnt_q == '0) ? reload : cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/wdt_slowclk_fault.sv
`timescale 1ns/1ps
module wdt_slowclk_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic unf_ev,
  input  logic werr_ev,
  input  logic rd_clr,
  input  logic irq_en,
  input  logic rst_en,
  output logic sts_unf,
  output logic sts_werr,
  output logic fault_irq_o,
  output logic rst_req_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_unf   <= 1'b0;
      sts_werr  <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      sts_unf   <= (sts_unf  & ~rd_clr) | unf_ev;
      sts_werr  <= (sts_werr & ~rd_clr) | werr_ev;
      rst_req_o <= (unf_ev | werr_ev) & rst_en;
    end
  end

  assign fault_irq_o = irq_en & (sts_unf | sts_werr);
endmodule

// File: rtl/wdt_slowclk.sv
`timescale 1ns/1ps
module wdt_slowclk
  import wdt_slowclk_pkg::*;
#(
  parameter int PRESC_DIV = 128,
  parameter int LOCK_CYC  = 3,
  parameter int DEF_SECS  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        idle_i,
  input  logic        dbg_i,
  output logic        fault_irq_o,
  output logic        rst_req_o
);
  mode_t            mode_q;
  logic             ctrl_rst_ev, mode_wr_ev, restart_ev, lock_active;
  logic [CNT_W-1:0] load_val, cnt_q;
  logic             unf_ev, werr_ev, run_en, rd_clr;
  logic             sts_unf, sts_werr;

  wdt_slowclk_regs #(.LOCK_CYC(LOCK_CYC), .DEF_SECS(DEF_SECS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode_q(mode_q), .ctrl_rst_ev(ctrl_rst_ev), .mode_wr_ev(mode_wr_ev),
    .restart_ev(restart_ev), .load_val(load_val), .lock_active(lock_active)
  );

  assign run_en  = ~mode_q.dis & ~((mode_q.idle_halt & idle_i) | (mode_q.dbg_halt & dbg_i));
  assign werr_ev = ctrl_rst_ev & ~mode_q.dis & ~win_ok(cnt_q, mode_q.window);
  assign rd_clr  = rd_en & (addr == A_STAT);

  wdt_slowclk_counter #(.PRESC_DIV(PRESC_DIV), .DEF_SECS(DEF_SECS)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(restart_ev), .load_val(load_val),
    .reload(mode_q.reload), .run(run_en), .cnt_q(cnt_q), .unf_ev(unf_ev)
  );

  wdt_slowclk_fault flt_i (
    .clk(clk), .rst_n(rst_n), .unf_ev(unf_ev), .werr_ev(werr_ev), .rd_clr(rd_clr),
    .irq_en(mode_q.irq_en), .rst_en(mode_q.rst_en), .sts_unf(sts_unf),
    .sts_werr(sts_werr), .fault_irq_o(fault_irq_o), .rst_req_o(rst_req_o)
  );

  always_comb begin
    case (addr)
      A_MODE:  rdata = 32'(mode_q);
      A_STAT:  rdata = {30'b0, sts_werr, sts_unf};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_slowclk_chk.sv
`timescale 1ns/1ps
module wdt_slowclk_chk
  import wdt_slowclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [31:0]      wdata,
  input logic             idle_i,
  input logic             dbg_i,
  input mode_t            mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ctrl_rst_ev,
  input logic             mode_wr_ev,
  input logic             restart_ev,
  input logic             lock_active,
  input logic             sts_unf,
  input logic             rst_req_o
);
  AST_CTRL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst_ev |=> cnt_q == $past(mode_q.reload)); // R3

  AST_LOCK_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ev |=> lock_active); // R5

  AST_LOCK_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && wr_en && addr == A_MODE) |=> $stable(mode_q)); // R5

  AST_DIS_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_ev && wdata[24]) |=> ($stable(mode_q.reload) && $stable(mode_q.window))); // R6

  AST_UNF_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_unf) |-> $past(cnt_q) == '0); // R2

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.idle_halt && idle_i && !restart_ev) |=> $stable(cnt_q)); // R8

  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.dbg_halt && dbg_i && !restart_ev) |=> $stable(cnt_q)); // R8

  AST_DIS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.dis && !restart_ev) |=> $stable(cnt_q)); // R11

  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> mode_q.rst_en); // R7
endmodule

bind wdt_slowclk wdt_slowclk_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .idle_i(idle_i), .dbg_i(dbg_i), .mode_q(mode_q), .cnt_q(cnt_q),
  .ctrl_rst_ev(ctrl_rst_ev), .mode_wr_ev(mode_wr_ev), .restart_ev(restart_ev),
  .lock_active(lock_active), .sts_unf(sts_unf), .rst_req_o(rst_req_o)
);

// File: tb/wdt_slowclk_tb_top.sv
`timescale 1ns/1ps
module wdt_slowclk_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] KEY_OK  = 32'hA500_0001;
  localparam logic [31:0] KEY_BAD = 32'h5A00_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        idle_i = 1'b0, dbg_i = 1'b0;
  logic        fault_irq_o, rst_req_o;
  int          total = 0, bad = 0;
  logic [31:0] rv;

  always #(CLK_P/2) clk = ~clk;

  wdt_slowclk dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .idle_i(idle_i), .dbg_i(dbg_i),
    .fault_irq_o(fault_irq_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [31:0] mk(input logic [11:0] rl, input logic [11:0] win,
                                     input logic dis, input logic ie, input logic re,
                                     input logic ih, input logic dh);
    return {3'b0, dh, ih, re, ie, dis, win, rl};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] q);
    rd_en = 1'b1; addr = a;
    #1 q = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    bus_rd(2'd1, rv); chk("R1 mode", rv, 32'h01FF_FFFF);
    bus_rd(2'd2, rv); chk("R1 status", rv, 32'h0);
    chk("R1 irq", 32'(fault_irq_o), 32'h0);
    chk("R1 rst", 32'(rst_req_o), 32'h0);
  endtask

  task automatic t_disable;
    bus_wr(2'd1, mk(12'd3, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_n(3);
    bus_wr(2'd1, mk(12'd5, 12'h000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
    bus_rd(2'd1, rv); chk("R6 fields kept", rv, mk(12'd3, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_n(1000);
    bus_rd(2'd2, rv); chk("R11 no underflow", rv, 32'h0);
    chk("R11 irq", 32'(fault_irq_o), 32'h0);
  endtask

  task automatic t_underflow;
    wait_n(5); bus_rd(2'd2, rv);
    bus_wr(2'd1, mk(12'd3, 12'hFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
    wait_n(511); chk("R4 irq before", 32'(fault_irq_o), 32'h0);
    wait_n(1);   chk("R2 irq at 512", 32'(fault_irq_o), 32'h1);
                 chk("R7 rst pulse", 32'(rst_req_o), 32'h1);
    wait_n(1);   chk("R7 rst one clk", 32'(rst_req_o), 32'h0);
    bus_rd(2'd2, rv); chk("R10 status unf", rv, 32'h1);
    bus_rd(2'd2, rv); chk("R10 cleared", rv, 32'h0);
    chk("R7 irq drops", 32'(fault_irq_o), 32'h0);
    wait_n(508); chk("R2 reload before", 32'(fault_irq_o), 32'h0);
    wait_n(1);   chk("R2 second underflow", 32'(fault_irq_o), 32'h1);
  endtask

  task automatic t_key;
    wait_n(5); bus_rd(2'd2, rv);
    bus_wr(2'd1, mk(12'd3, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_n(99);
    bus_wr(2'd0, KEY_BAD);
    bus_wr(2'd0, KEY_OK);
    wait_n(511); chk("R3 bad key ignored", 32'(fault_irq_o), 32'h0);
    wait_n(1);   chk("R3 keyed restart", 32'(fault_irq_o), 32'h1);
  endtask

  task automatic t_lock;
    wait_n(5); bus_rd(2'd2, rv);
    bus_wr(2'd1, mk(12'd3, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_n(2);
    bus_wr(2'd1, mk(12'd7, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    bus_rd(2'd1, rv); chk("R5 third clk ignored", rv, mk(12'd3, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_n(5);
    bus_wr(2'd1, mk(12'd3, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_n(3);
    bus_wr(2'd1, mk(12'd9, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    bus_wr(2'd0, KEY_OK);
    bus_rd(2'd1, rv); chk("R5 fourth clk accepted", rv, mk(12'd9, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_n(1277); chk("R5 locked restart ignored", 32'(fault_irq_o), 32'h0);
    wait_n(1);    chk("R4 new reload timing", 32'(fault_irq_o), 32'h1);
  endtask

  task automatic t_window;
    wait_n(5); bus_rd(2'd2, rv);
    bus_wr(2'd1, mk(12'd3, 12'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_n(9);
    bus_wr(2'd0, KEY_OK);
    chk("R9 early restart fault", 32'(fault_irq_o), 32'h1);
    bus_rd(2'd2, rv); chk("R9 status werr", rv, 32'h2);
    wait_n(288);
    bus_wr(2'd0, KEY_OK);
    bus_rd(2'd2, rv); chk("R9 in-window no flag", rv, 32'h0);
    wait_n(221); chk("R9 valid restart reloads", 32'(fault_irq_o), 32'h0);
    wait_n(289); chk("R9 before underflow", 32'(fault_irq_o), 32'h0);
    wait_n(1);   chk("R9 underflow after reload", 32'(fault_irq_o), 32'h1);
  endtask

  task automatic t_idle;
    wait_n(5); bus_rd(2'd2, rv);
    bus_wr(2'd1, mk(12'd1, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
    wait_n(10); idle_i = 1'b1;
    wait_n(50); idle_i = 1'b0;
    wait_n(245); chk("R8 idle extends", 32'(fault_irq_o), 32'h0);
    wait_n(1);   chk("R8 idle underflow", 32'(fault_irq_o), 32'h1);
  endtask

  task automatic t_dbg;
    wait_n(5); bus_rd(2'd2, rv);
    bus_wr(2'd1, mk(12'd1, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
    wait_n(10); dbg_i = 1'b1; idle_i = 1'b1;
    wait_n(20); dbg_i = 1'b0;
    wait_n(10); idle_i = 1'b0;
    wait_n(235); chk("R8 dbg extends", 32'(fault_irq_o), 32'h0);
    wait_n(1);   chk("R8 idle without bit no effect", 32'(fault_irq_o), 32'h1);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL R0 watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_disable();
    t_underflow();
    t_key();
    t_lock();
    t_window();
    t_idle();
    t_dbg();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule